// File: doc/BRIEF.md
# Word Load/Store Execution Unit

This unit executes the three word-sized memory operations of a 64-bit register machine: load a word and zero-extend it, store a word, and store a word while writing the computed address back into the base register. The issue logic hands it one decoded operation at a time. Each operation comes with the base register index and its value, the source register value for stores, the destination register index for loads and a 16-bit signed displacement.

The unit forms the effective address and places one 4-byte request on a simple memory port. It holds that request until the memory accepts it. A load then waits for a separate read response. Register results leave on a one-cycle writeback strobe. A busy output covers the whole life of an operation, and the issue side may present a new one only once busy is low.

Top module: `lsu_word_unit`

## Requirements
- R1: The request address equals the base plus the displacement sign-extended to 64 bits, with any carry out of bit 63 discarded (the sum wraps modulo 2^64).
- R2: For a load (op_kind 0) or a plain store (op_kind 1) whose base index is 0, the base is zero and base_val is ignored. For any other index the base is base_val.
- R3: For the store-with-update (op_kind 2), the base is always base_val, even when the base index is 0. After the memory accepts the store, one writeback carries the effective address to the base index.
- R4: A load writes back to dst_idx, with the 32 returned bits in bits 31:0 and zeros in bits 63:32. wb_valid rises in the cycle after the one in which mem_rvalid is sampled high, and it lasts exactly one cycle.
- R5: Stores drive mem_we=1 and mem_wdata equal to bits 31:0 of src_val. Loads drive mem_we=0. mem_size is always 2, which is log2 of the 4-byte access.
- R6: mem_req rises in the cycle after acceptance. It stays high with mem_addr, mem_we and mem_wdata unchanged until a cycle in which mem_ready is high, and it drops in the next cycle.
- R7: busy rises in the cycle after an operation is accepted and falls once the operation has completed. op_valid presented while busy is ignored. A plain store produces no writeback.
- R8: op_kind 3 is reserved. Presenting it is not accepted: busy stays low and no memory request is made.
- R9: Following reset, busy, mem_req and wb_valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented |
| op_kind | input | 2 | 0 load-zero, 1 store, 2 store-with-update, 3 reserved |
| base_idx | input | 5 | Base register index |
| base_val | input | 64 | Base register value |
| dst_idx | input | 5 | Load destination register index |
| src_val | input | 64 | Store source register value |
| disp | input | 16 | Signed displacement |
| busy | output | 1 | An operation is in flight |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 64 | Request byte address |
| mem_size | output | 3 | log2 of the access size in bytes (always 2) |
| mem_wdata | output | 32 | Store data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| wb_valid | output | 1 | Register writeback strobe |
| wb_idx | output | 5 | Writeback register index |
| wb_data | output | 64 | Writeback value |

## Verification
Three cases are hard to reach from the ports. The first is the update store whose base index is 0: it must use base_val, while a load with the same fields must not. The bench issues both cases with a deliberately non-zero base_val, so mixing up the two base rules changes the observed address. The second is a second operation presented while busy, which is only visible if the memory stalls. The bench's memory model holds off mem_ready for a programmable number of cycles, keeps op_valid asserted with store fields throughout the stall, and checks that only one read reaches memory. The third is an address that wraps past 2^64, reached with a base close to all-ones and a positive displacement.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    LSU_LWZ  = 2'd0,
    LSU_STW  = 2'd1,
    LSU_STWU = 2'd2,
    LSU_RSVD = 2'd3
  } lsu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RESP = 2'd2,
    ST_WB   = 2'd3
  } lsu_state_e;
endpackage

// File: rtl/lsu_ea.sv
module lsu_ea
  import lsu_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int DISP_W = 16,
  parameter int IDX_W  = 5
) (
  input  lsu_op_e            op,
  input  logic [IDX_W-1:0]   ra_idx,
  input  logic [XLEN-1:0]    ra_val,
  input  logic [DISP_W-1:0]  disp,
  output logic [XLEN-1:0]    ea,
  output logic               base_zero
);
  localparam int EXT_W = XLEN - DISP_W;

  function automatic logic [XLEN-1:0] sext_disp(input logic [DISP_W-1:0] d);
    return {{EXT_W{d[DISP_W-1]}}, d};
  endfunction

  function automatic logic [XLEN-1:0] add_wrap(input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [XLEN:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[XLEN-1:0];
  endfunction

  logic [XLEN-1:0] base;

  // update form always uses the register value as base
  assign base_zero = (op != LSU_STWU) && (ra_idx == '0);
  assign base      = base_zero ? '0 : ra_val;
  assign ea        = add_wrap(base, sext_disp(disp));
endmodule

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
  import lsu_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int WORD_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  lsu_op_e            op,
  input  logic [IDX_W-1:0]   ra_idx,
  input  logic [IDX_W-1:0]   rt_idx,
  input  logic [XLEN-1:0]    ea,
  input  logic [XLEN-1:0]    rs_val,
  input  logic               mem_ready,
  input  logic               mem_rvalid,
  input  logic [WORD_W-1:0]  mem_rdata,
  output logic               accept,
  output logic               busy,
  output logic               mem_req,
  output logic               mem_we,
  output logic [XLEN-1:0]    mem_addr,
  output logic [WORD_W-1:0]  mem_wdata,
  output logic               wb_valid,
  output logic               wb_is_load,
  output logic [IDX_W-1:0]   wb_idx,
  output logic [XLEN-1:0]    ea_q,
  output logic [WORD_W-1:0]  rdata_q
);
  lsu_state_e         state, state_nx;
  lsu_op_e            op_q;
  logic [IDX_W-1:0]   ra_q, rt_q;
  logic [WORD_W-1:0]  wdata_q;
  logic               req_taken, resp_seen;
  logic               unused_rs_hi;

  assign unused_rs_hi = ^rs_val[XLEN-1:WORD_W];

  assign accept    = op_valid && (state == ST_IDLE) && (op != LSU_RSVD);
  assign req_taken = (state == ST_REQ) && mem_ready;
  assign resp_seen = (state == ST_RESP) && mem_rvalid;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: if (accept) state_nx = ST_REQ;
      ST_REQ: if (req_taken) begin
        case (op_q)
          LSU_LWZ:  state_nx = ST_RESP;
          LSU_STWU: state_nx = ST_WB;
          default:  state_nx = ST_IDLE;
        endcase
      end
      ST_RESP: if (mem_rvalid) state_nx = ST_WB;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      op_q    <= LSU_LWZ;
      ra_q    <= '0;
      rt_q    <= '0;
      ea_q    <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      state <= state_nx;
      if (accept) begin
        op_q    <= op;
        ra_q    <= ra_idx;
        rt_q    <= rt_idx;
        ea_q    <= ea;
        wdata_q <= rs_val[WORD_W-1:0];
      end
      if (resp_seen) rdata_q <= mem_rdata;
    end
  end

  assign busy       = (state != ST_IDLE);
  assign mem_req    = (state == ST_REQ);
  assign mem_we     = (op_q != LSU_LWZ);
  assign mem_addr   = ea_q;
  assign mem_wdata  = wdata_q;
  assign wb_valid   = (state == ST_WB);
  assign wb_is_load = (op_q == LSU_LWZ);
  assign wb_idx     = wb_is_load ? rt_q : ra_q;

  // R6: a request not yet accepted is held unchanged
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata)));

  // R6: request drops after acceptance
  p_req_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready) |=> !mem_req);

  // R7: latched operation not overwritten while in flight
  p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wb_valid && !(mem_req && mem_ready && op_q == LSU_STW)) |=> $stable(ea_q));

  // R4: load response leads to exactly the next-cycle writeback
  p_load_wb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    resp_seen |=> (wb_valid && wb_is_load && wb_idx == $past(rt_q)));

  // R3: update store writes the base register after acceptance
  p_stwu_wb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_taken && op_q == LSU_STWU) |=> (wb_valid && !wb_is_load && wb_idx == $past(ra_q)));
endmodule

// File: rtl/lsu_wb_fmt.sv
module lsu_wb_fmt #(
  parameter int XLEN   = 64,
  parameter int WORD_W = 32
) (
  input  logic               is_load,
  input  logic [XLEN-1:0]    ea_q,
  input  logic [WORD_W-1:0]  rdata_q,
  output logic [XLEN-1:0]    wb_data
);
  logic [XLEN-1:0] load_val;

  generate
    if (XLEN > WORD_W) begin : g_zext
      assign load_val = {{(XLEN-WORD_W){1'b0}}, rdata_q};
    end else begin : g_full
      assign load_val = rdata_q[XLEN-1:0];
    end
  endgenerate

  assign wb_data = is_load ? load_val : ea_q;
endmodule

// File: rtl/lsu_word_unit.sv
module lsu_word_unit
  import lsu_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int WORD_W = 32,
  parameter int DISP_W = 16,
  parameter int IDX_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic [1:0]         op_kind,
  input  logic [IDX_W-1:0]   base_idx,
  input  logic [XLEN-1:0]    base_val,
  input  logic [IDX_W-1:0]   dst_idx,
  input  logic [XLEN-1:0]    src_val,
  input  logic [DISP_W-1:0]  disp,
  output logic               busy,
  output logic               mem_req,
  output logic               mem_we,
  output logic [XLEN-1:0]    mem_addr,
  output logic [2:0]         mem_size,
  output logic [WORD_W-1:0]  mem_wdata,
  input  logic               mem_ready,
  input  logic               mem_rvalid,
  input  logic [WORD_W-1:0]  mem_rdata,
  output logic               wb_valid,
  output logic [IDX_W-1:0]   wb_idx,
  output logic [XLEN-1:0]    wb_data
);
  localparam int EXT_W     = XLEN - DISP_W;
  localparam int SIZE_CODE = $clog2(WORD_W / 8);

  lsu_op_e           op;
  logic [XLEN-1:0]   ea, ea_q;
  logic [WORD_W-1:0] rdata_q;
  logic              base_zero, accept, wb_is_load;

  assign op       = lsu_op_e'(op_kind);
  assign mem_size = 3'(SIZE_CODE);

  lsu_ea #(.XLEN(XLEN), .DISP_W(DISP_W), .IDX_W(IDX_W)) u_ea (
    .op(op), .ra_idx(base_idx), .ra_val(base_val), .disp(disp),
    .ea(ea), .base_zero(base_zero)
  );

  lsu_ctrl #(.XLEN(XLEN), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op),
    .ra_idx(base_idx), .rt_idx(dst_idx), .ea(ea), .rs_val(src_val),
    .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .accept(accept), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .wb_valid(wb_valid),
    .wb_is_load(wb_is_load), .wb_idx(wb_idx), .ea_q(ea_q), .rdata_q(rdata_q)
  );

  lsu_wb_fmt #(.XLEN(XLEN), .WORD_W(WORD_W)) u_wb (
    .is_load(wb_is_load), .ea_q(ea_q), .rdata_q(rdata_q), .wb_data(wb_data)
  );

  // R8: reserved code never starts an operation
  p_rsvd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && op_valid && op_kind == 2'd3) |=> !busy);

  // R2: zero base gives the bare sign-extended displacement
  p_zero_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && base_zero) |=> (mem_addr == {{EXT_W{$past(disp[DISP_W-1])}}, $past(disp)}));

  // R4: writeback is a single-cycle strobe
  p_wb_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid);

  // R7: acceptance starts the busy window with a request
  p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && mem_req));
endmodule

// File: tb/tb_lsu_word_unit.sv
module tb_lsu_word_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        op_valid = 0;
  logic [1:0]  op_kind = 0;
  logic [4:0]  base_idx = 0, dst_idx = 0;
  logic [63:0] base_val = 0, src_val = 0;
  logic [15:0] disp = 0;
  logic        busy, mem_req, mem_we, wb_valid;
  logic [63:0] mem_addr, wb_data;
  logic [2:0]  mem_size;
  logic [31:0] mem_wdata;
  logic        mem_ready = 0, mem_rvalid = 0;
  logic [31:0] mem_rdata = 0;
  logic [4:0]  wb_idx;

  lsu_word_unit dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .base_idx(base_idx), .base_val(base_val), .dst_idx(dst_idx),
    .src_val(src_val), .disp(disp), .busy(busy), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [31:0] mem [16];
  int ready_delay = 0, wait_cnt = 0, req_cycles = 0;
  int acc_cnt = 0, wr_cnt = 0, wb_cnt = 0;
  logic [63:0] acc_addr;
  logic        acc_we;
  logic [31:0] acc_wdata, rd_hold;
  logic [2:0]  acc_size;
  bit          pend_read = 0;
  logic [4:0]  last_wb_idx;
  logic [63:0] last_wb_data;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] want_ea(input logic [1:0] k, input logic [4:0] idx,
                                          input logic [63:0] v, input logic [15:0] d);
    logic [63:0] b;
    logic [63:0] dx;
    b  = (k != 2'd2 && idx == 5'd0) ? 64'd0 : v;
    dx = d[15] ? (64'hFFFF_FFFF_FFFF_0000 | 64'(d)) : 64'(d);
    return b + dx;
  endfunction

  // memory model and monitor in one negedge process
  initial forever begin
    @(negedge clk);
    if (wb_valid) begin
      wb_cnt++; last_wb_idx = wb_idx; last_wb_data = wb_data;
    end
    mem_ready = 0; mem_rvalid = 0;
    if (pend_read) begin
      mem_rvalid = 1; mem_rdata = rd_hold; pend_read = 0;
    end else if (mem_req) begin
      req_cycles++;
      if (wait_cnt >= ready_delay) begin
        mem_ready = 1; wait_cnt = 0; acc_cnt++;
        acc_addr = mem_addr; acc_we = mem_we; acc_wdata = mem_wdata; acc_size = mem_size;
        if (mem_we) begin mem[mem_addr[5:2]] = mem_wdata; wr_cnt++; end
        else begin rd_hold = mem[mem_addr[5:2]]; pend_read = 1; end
      end else wait_cnt++;
    end
  end

  task automatic run_op(input logic [1:0] k, input logic [4:0] bi, input logic [63:0] bv,
                        input logic [4:0] di, input logic [63:0] sv, input logic [15:0] d);
    @(negedge clk);
    op_valid = 1; op_kind = k; base_idx = bi; base_val = bv;
    dst_idx = di; src_val = sv; disp = d;
    @(negedge clk);
    op_valid = 0;
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(busy == 0, "R9", "busy", 64'(busy), 0);
    check(mem_req == 0, "R9", "mem_req", 64'(mem_req), 0);
    check(wb_valid == 0, "R9", "wb_valid", 64'(wb_valid), 0);
  endtask

  task automatic t_load_basic();
    int a0 = acc_cnt, w0 = wb_cnt;
    logic [63:0] e = want_ea(0, 5, 64'h1000_0000_0000_0020, 16'h0004);
    run_op(0, 5, 64'h1000_0000_0000_0020, 11, 64'h0, 16'h0004);
    check(acc_addr == e, "R1", "load addr", acc_addr, e);
    check(acc_we == 0, "R5", "load we", 64'(acc_we), 0);
    check(acc_size == 3'd2, "R5", "size", 64'(acc_size), 2);
    check(acc_cnt == a0 + 1, "R6", "one request", 64'(acc_cnt), 64'(a0 + 1));
    check(wb_cnt == w0 + 1 && last_wb_idx == 11, "R4", "wb idx", 64'(last_wb_idx), 11);
    check(last_wb_data == {32'd0, mem[e[5:2]]}, "R4", "zero-extended data",
          last_wb_data, {32'd0, mem[e[5:2]]});
  endtask

  task automatic t_load_ra0();
    run_op(0, 0, 64'h0BAD_0BAD_0BAD_0BAD, 3, 64'h0, 16'h0008);
    check(acc_addr == 64'h8, "R2", "ra0 load base zero", acc_addr, 64'h8);
    check(last_wb_data == {32'd0, mem[2]}, "R4", "ra0 load data", last_wb_data, {32'd0, mem[2]});
    run_op(1, 0, 64'h5555_0000_0000_0000, 0, 64'h0, 16'h8000);
    check(acc_addr == 64'hFFFF_FFFF_FFFF_8000, "R2", "ra0 store neg disp",
          acc_addr, 64'hFFFF_FFFF_FFFF_8000);
  endtask

  task automatic t_store_neg();
    int w0 = wb_cnt;
    run_op(1, 3, 64'h2000_0040, 0, 64'hCAFE_F00D_1234_5678, 16'hFFF8);
    check(acc_addr == 64'h2000_0038, "R1", "neg disp store", acc_addr, 64'h2000_0038);
    check(acc_we == 1 && acc_wdata == 32'h1234_5678, "R5", "store data",
          64'(acc_wdata), 64'h1234_5678);
    check(wb_cnt == w0, "R7", "store no wb", 64'(wb_cnt), 64'(w0));
    run_op(0, 3, 64'h2000_0040, 9, 64'h0, 16'hFFF8);
    check(last_wb_data == 64'h1234_5678, "R4", "reload stored word", last_wb_data, 64'h1234_5678);
  endtask

  task automatic t_update();
    int w0 = wb_cnt;
    run_op(2, 7, 64'h3000_0100, 0, 64'h0000_0000_89AB_CDEF, 16'hFFFC);
    check(acc_addr == 64'h3000_00FC, "R3", "update addr", acc_addr, 64'h3000_00FC);
    check(mem[15] == 32'h89AB_CDEF, "R5", "update store data", 64'(mem[15]), 64'h89AB_CDEF);
    check(wb_cnt == w0 + 1 && last_wb_idx == 7, "R3", "update wb idx", 64'(last_wb_idx), 7);
    check(last_wb_data == 64'h3000_00FC, "R3", "update wb data", last_wb_data, 64'h3000_00FC);
    run_op(2, 0, 64'h4000_0010, 0, 64'h1, 16'h0010);
    check(acc_addr == 64'h4000_0020, "R3", "update idx0 uses value", acc_addr, 64'h4000_0020);
    check(last_wb_idx == 0 && last_wb_data == 64'h4000_0020, "R3", "update idx0 wb",
          last_wb_data, 64'h4000_0020);
  endtask

  task automatic t_wrap();
    run_op(0, 2, 64'hFFFF_FFFF_FFFF_FFF8, 4, 64'h0, 16'h0010);
    check(acc_addr == 64'h8, "R1", "wrap", acc_addr, 64'h8);
  endtask

  task automatic t_busy_ignore();
    int a0 = acc_cnt, wr0 = wr_cnt, rc0;
    ready_delay = 3;
    rc0 = req_cycles;
    @(negedge clk);
    op_valid = 1; op_kind = 0; base_idx = 1; base_val = 64'h40; dst_idx = 6; disp = 0;
    @(negedge clk);
    op_kind = 1; base_val = 64'h80; src_val = 64'hFFFF_FFFF;
    check(busy == 1, "R7", "busy after accept", 64'(busy), 1);
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    op_valid = 0;
    check(acc_cnt == a0 + 1, "R7", "held op ignored", 64'(acc_cnt), 64'(a0 + 1));
    check(wr_cnt == wr0, "R7", "no write from ignored op", 64'(wr_cnt), 64'(wr0));
    check(req_cycles - rc0 == 4, "R6", "request held through stall",
          64'(req_cycles - rc0), 4);
    check(acc_addr == 64'h40, "R6", "held address", acc_addr, 64'h40);
    ready_delay = 0;
  endtask

  task automatic t_reserved();
    int a0 = acc_cnt;
    @(negedge clk);
    op_valid = 1; op_kind = 3; base_idx = 1; base_val = 64'h100;
    @(negedge clk);
    op_valid = 0;
    check(busy == 0, "R8", "reserved not busy", 64'(busy), 0);
    @(negedge clk); @(negedge clk);
    check(acc_cnt == a0 && mem_req == 0, "R8", "reserved no request", 64'(acc_cnt), 64'(a0));
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h8000_0000 | (32'(i) * 32'h0101_0101);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_load_basic();
    t_load_ra0();
    t_store_neg();
    t_update();
    t_wrap();
    t_busy_ignore();
    t_reserved();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule